// File: doc/BRIEF.md
# Threshold-Qualified Priority Request Encoder

This block turns a vector of eight request lines and a 3-bit priority floor into two results. The first is the index of the most important asserted line, where a larger line number always outranks a smaller one. The second is a single flag, `pend_o`, that says whether that winning request is allowed through under the floor set by software. The block holds no state apart from an optional output stage. Software changes the floor to hold back lower-importance requests while urgent work runs.

Index 0 carries two meanings: either no line is asserted, or only line 0 is asserted. The flag tells these two cases apart, because it is qualified by an internal "any request" term. The decode is split into four-input group encoders, a group selector and a comparator. The `REG_OUT` parameter chooses between combinational outputs and outputs registered once on the clock.

Top module: `irq_prio_thresh`

## Requirements
- R1: `id_o` equals the bit position of the most significant 1 in `req_i`, where bit k of `req_i` is request line k.
- R2: When `req_i` is all zeros, `id_o` is 0.
- R3: When any request is asserted, `pend_o` is 1 exactly when `id_o >= limit_i`, compared as unsigned 3-bit values.
- R4: When `req_i` is all zeros, `pend_o` is 0 for every value of `limit_i`.
- R5: Once request line k is asserted, the values on lines below k do not change `id_o` or `pend_o`.
- R6: With `REG_OUT=1` (the default), the outputs reflect the inputs present at the preceding rising clock edge. While `rst_ni` is low, `id_o` is 0 and `pend_o` is 0.
- R7: When line 0 is the only asserted request, `id_o` is 0 and `pend_o` is 1 only for `limit_i` equal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Request lines; bit k is line k, and a higher k has higher priority |
| limit_i | input | 3 | Lowest winning index that raises the flag |
| id_o | output | 3 | Index of the highest asserted line |
| pend_o | output | 1 | Winning request is at or above the limit |

## Verification
The bench sweeps every request pattern against every limit value, so the selector and the comparator are each exercised on every input they can receive. Single-line patterns show that each group encoder and the group selector map a line to its own index. Patterns with a fixed top line and varying lower lines show that lower lines have no effect. The empty vector and the lone line-0 vector, each tried across all limits, show whether the flag separates the two cases that share index 0. A short set of mixed vectors, each paired with a limit just above, at or below its winner, checks the edges of the compare.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned GRP_W     = 4;
  localparam int unsigned GRP_IDX_W = $clog2(GRP_W);

  typedef struct packed {
    logic                 vld;
    logic [GRP_IDX_W-1:0] idx;
  } grp_hit_t;
endpackage

// File: rtl/irq_grp_enc.sv
module irq_grp_enc
  import irq_pkg::*;
(
  input  logic [GRP_W-1:0] req_i,
  output grp_hit_t         hit_o
);
  always_comb begin
    hit_o = '0;
    for (int i = 0; i < GRP_W; i++) begin
      if (req_i[i]) begin
        hit_o.vld = 1'b1;
        hit_o.idx = GRP_IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_grp_sel.sv
module irq_grp_sel
  import irq_pkg::*;
#(
  parameter int unsigned N_GRP = 2,
  localparam int unsigned ID_W = $clog2(N_GRP * GRP_W)
) (
  input  grp_hit_t        hits_i [N_GRP],
  output logic            any_o,
  output logic [ID_W-1:0] id_o
);
  localparam int unsigned GSEL_W = ID_W - GRP_IDX_W;

  // later (higher) groups override earlier ones
  always_comb begin
    any_o = 1'b0;
    id_o  = '0;
    for (int g = 0; g < N_GRP; g++) begin
      if (hits_i[g].vld) begin
        any_o = 1'b1;
        id_o  = {GSEL_W'(g), hits_i[g].idx};
      end
    end
  end
endmodule

// File: rtl/irq_lim_cmp.sv
module irq_lim_cmp #(
  parameter int unsigned ID_W = 3
) (
  input  logic            any_i,
  input  logic [ID_W-1:0] id_i,
  input  logic [ID_W-1:0] limit_i,
  output logic            ge_o
);
  assign ge_o = any_i & (id_i >= limit_i);
endmodule

// File: rtl/irq_prio_thresh.sv
module irq_prio_thresh
  import irq_pkg::*;
#(
  parameter int unsigned N_REQ   = 8,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned ID_W   = $clog2(N_REQ),
  localparam int unsigned N_GRP  = N_REQ / GRP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  input  logic [ID_W-1:0]  limit_i,
  output logic [ID_W-1:0]  id_o,
  output logic             pend_o
);
  grp_hit_t        hits [N_GRP];
  logic            any_req;
  logic [ID_W-1:0] id_d;
  logic            pend_d;

  for (genvar g = 0; g < N_GRP; g++) begin : g_enc
    irq_grp_enc i_enc (
      .req_i (req_i[g*GRP_W +: GRP_W]),
      .hit_o (hits[g])
    );
  end

  irq_grp_sel #(.N_GRP(N_GRP)) i_sel (
    .hits_i (hits),
    .any_o  (any_req),
    .id_o   (id_d)
  );

  irq_lim_cmp #(.ID_W(ID_W)) i_cmp (
    .any_i   (any_req),
    .id_i    (id_d),
    .limit_i (limit_i),
    .ge_o    (pend_d)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        id_o   <= '0;
        pend_o <= 1'b0;
      end else begin
        id_o   <= id_d;
        pend_o <= pend_d;
      end
    end
  end else begin : g_comb
    assign id_o   = id_d;
    assign pend_o = pend_d;
  end
endmodule

// File: rtl/irq_prio_thresh_chk.sv
module irq_prio_thresh_chk #(
  parameter int unsigned N_REQ   = 8,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned ID_W   = $clog2(N_REQ)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_REQ-1:0] req_i,
  input logic [ID_W-1:0]  limit_i,
  input logic [ID_W-1:0]  id_o,
  input logic             pend_o
);
  logic [N_REQ-1:0] req_v;
  logic [ID_W-1:0]  lim_v;
  logic             vld;

  if (REG_OUT) begin : g_seq
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_v <= '0;
        lim_v <= '0;
        vld   <= 1'b0;
      end else begin
        req_v <= req_i;
        lim_v <= limit_i;
        vld   <= 1'b1;
      end
    end
  end else begin : g_cmb
    assign req_v = req_i;
    assign lim_v = limit_i;
    assign vld   = 1'b1;
  end

  p_id_top_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld && req_v != '0) |-> (req_v[id_o] && ((req_v >> id_o) == N_REQ'(1))));

  p_idle_id_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld && req_v == '0) |-> (id_o == '0));

  p_pend_cmp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld && req_v != '0) |-> (pend_o == (id_o >= lim_v)));

  p_idle_pend_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld && req_v == '0) |-> !pend_o);

  p_reset_out_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld |-> (id_o == '0 && !pend_o));

  p_lone_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld && req_v == N_REQ'(1)) |-> (id_o == '0 && pend_o == (lim_v == '0)));
endmodule

bind irq_prio_thresh irq_prio_thresh_chk #(
  .N_REQ   (N_REQ),
  .REG_OUT (REG_OUT)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .limit_i (limit_i),
  .id_o    (id_o),
  .pend_o  (pend_o)
);

// File: tb/test_irq_prio_thresh.sv
module test_irq_prio_thresh;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic [2:0] lim = '0;
  logic [2:0] id;
  logic       pend;
  int         n_chk = 0;
  int         n_err = 0;

  always #2 clk = ~clk;

  irq_prio_thresh i_irq_prio_thresh (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .req_i   (req),
    .limit_i (lim),
    .id_o    (id),
    .pend_o  (pend)
  );

  function automatic logic [2:0] ref_id(input logic [7:0] r);
    ref_id = 3'd0;
    for (int k = 0; k < 8; k++) if (r[k]) ref_id = 3'(k);
  endfunction

  function automatic logic ref_pend(input logic [7:0] r, input logic [2:0] l);
    ref_pend = (r != 8'd0) && (ref_id(r) >= l);
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s req=%b lim=%0d actual=%0d expected=%0d", tag, req, lim, act, exp);
    end
  endtask

  // inputs change just after a negedge; result sampled at the following negedge
  task automatic apply(input logic [7:0] r, input logic [2:0] l);
    req = r;
    lim = l;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic apply_chk(input string tag, input logic [7:0] r, input logic [2:0] l);
    apply(r, l);
    chk({tag, " id"},   {1'b0, id},   {1'b0, ref_id(r)});
    chk({tag, " pend"}, {3'b0, pend}, {3'b0, ref_pend(r, l)});
  endtask

  task automatic t_reset;
    req = 8'hff;
    lim = 3'd0;
    repeat (3) @(negedge clk);
    chk("R6 reset id",   {1'b0, id},   4'd0);
    chk("R6 reset pend", {3'b0, pend}, 4'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 latency id", {1'b0, id}, 4'd7);
  endtask

  task automatic t_directed;
    apply_chk("R2_R4", 8'b0000_0000, 3'd0);
    apply_chk("R3",    8'b0000_1101, 3'd2);
    apply_chk("R3",    8'b0000_1101, 3'd3);
    apply_chk("R3",    8'b0000_1101, 3'd4);
    apply_chk("R1",    8'b1010_0010, 3'd6);
    apply_chk("R3",    8'b1000_0000, 3'd7);
    apply_chk("R5",    8'b0001_0001, 3'd0);
    apply_chk("R7",    8'b0000_0001, 3'd1);
    // one-cycle step: output follows the new inputs after exactly one edge
    apply(8'b0100_0000, 3'd0);
    req = 8'b0000_0010;
    @(posedge clk);
    #1;
    chk("R6 step", {1'b0, id}, 4'd1);
    @(negedge clk);
  endtask

  task automatic t_idle_and_lone_zero;
    for (int l = 0; l < 8; l++) apply_chk("R4", 8'h00, 3'(l));
    for (int l = 0; l < 8; l++) apply_chk("R7", 8'h01, 3'(l));
  endtask

  task automatic t_one_hot;
    for (int k = 0; k < 8; k++) apply_chk("R1", 8'(1 << k), 3'd0);
  endtask

  task automatic t_lower_masked;
    for (int k = 1; k < 8; k++) begin
      for (int lo = 0; lo < (1 << k); lo++) begin
        apply(8'(1 << k) | 8'(lo), 3'(k));
        chk("R5 id",   {1'b0, id},   4'(k));
        chk("R5 pend", {3'b0, pend}, 4'd1);
      end
    end
  endtask

  task automatic t_sweep;
    for (int r = 0; r < 256; r++)
      for (int l = 0; l < 8; l++)
        apply_chk("R1_R3", 8'(r), 3'(l));
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset();
        t_directed();
        t_idle_and_lone_zero();
        t_one_hot();
        t_lower_masked();
        t_sweep();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule